// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block serialises bytes onto a single asynchronous line. Software-style control inputs set the frame before a byte is sent. These inputs are an 11-bit bit-period divisor, written in two pieces, and a frame word. The frame word gives the character length (7, 8 or 9 data bits), one or two stop bits, a value for a ninth data bit, a parity mode and a parity enable. Each accepted byte becomes one frame on `tx_line`. The frame has a low start bit, the data bits least significant first, an optional parity bit or ninth bit, and then the high stop bits. Between frames the line rests high.

Bytes enter through a valid/ready stream port. `in_ready` is high only while no frame is in progress. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_data` steady until that edge. While a frame is being sent, `in_ready` stays low and `in_valid` and `in_data` are ignored. `busy` marks the frame in progress.

Each bit lasts (divisor + 1) × 16 clocks. The divisor and the frame word are copied into the transmitter when a byte is accepted. Writes made during a frame therefore shape only later frames. One character-length code also raises `loop_en`, which tells a neighbouring receiver to take its input from this line.

Top module: `utx_frame_tx`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0, `in_ready` is 1, `loop_en` is 0, and every control field is zero. A byte sent with no prior writes therefore produces 8 data bits, no parity and one stop bit.
- R2: `in_ready` equals the inverse of `busy`. A byte is accepted on an edge with `in_valid` and `in_ready` both 1, and `busy` is 1 from the next cycle until the frame ends. `in_valid` and `in_data` have no effect while `busy` is 1, and no second frame follows unless a new handshake occurs.
- R3: A frame is sent in this order: a start bit of 0, the data bits least significant first, the parity or ninth bit if present, and then the stop bits of 1. The line is 1 whenever `busy` is 0.
- R4: Every bit, including the start and stop bits, lasts (D + 1) × 16 clock cycles. D = {high[2:0], low[7:0]}. The low byte is written from `cfg_div_wdata[7:0]` with `cfg_div_lo_we`, and the high part from `cfg_div_wdata[2:0]` with `cfg_div_hi_we`.
- R5: `cfg_len` selects the data-bit count: 00 gives 8, 01 gives 7, and 10 or 11 gives 9. The parity bit is not counted. In 7-bit frames bit 7 of `in_data` is not sent.
- R6: In 9-bit frames the ninth data bit equals `cfg_bit9`. In 7-bit and 8-bit frames `cfg_bit9` has no effect.
- R7: When `cfg_pen` is 1 in a 7-bit or 8-bit frame, one parity bit follows the data, as selected by `cfg_pmode`. Code 00 gives odd parity, meaning the data plus parity hold an odd number of ones. Code 01 gives even parity, code 10 a constant 1, and code 11 a constant 0. No parity bit is sent when `cfg_pen` is 0 or in 9-bit frames.
- R8: `cfg_stop2` = 0 gives one stop bit and `cfg_stop2` = 1 gives two.
- R9: `loop_en` is 1 exactly when the stored character-length code is 11.
- R10: A divisor or frame-word write made while `busy` is 1 does not change the current frame's bits or bit length. It applies from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div_lo_we | input | 1 | Write strobe for divisor bits 7:0 |
| cfg_div_hi_we | input | 1 | Write strobe for divisor bits 10:8 |
| cfg_div_wdata | input | 8 | Divisor write data (bits 2:0 used by high write) |
| cfg_frm_we | input | 1 | Write strobe for the frame word |
| cfg_len | input | 2 | Character length code |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_bit9 | input | 1 | Ninth data bit value |
| cfg_pmode | input | 2 | Parity mode code |
| cfg_pen | input | 1 | Parity enable |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter idle, byte can be taken |
| in_data | input | 8 | Byte to send |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| loop_en | output | 1 | Loopback request flag |

## Verification
The hardest situation to reach from the ports is a control change, or a stray valid byte, arriving in the middle of a frame. The bench starts a frame and, in parallel branches, rewrites the frame word and the divisor and pulses `in_valid` with different data while `busy` is high. It then checks every bit of that frame against the old format and old bit length, and checks that the next frame uses the new ones. A large divisor with nonzero high bits is measured by counting the cycles of the start bit.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int MAX_DATA = 9;
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    LEN_8      = 2'b00,
    LEN_7      = 2'b01,
    LEN_9      = 2'b10,
    LEN_9_LOOP = 2'b11
  } len_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } pmode_e;

  typedef struct packed {
    len_e   len;
    logic   stop2;
    logic   bit9;
    pmode_e pmode;
    logic   pen;
  } frm_cfg_t;
endpackage

// File: rtl/utx_cfg_regs.sv
module utx_cfg_regs
  import utx_pkg::*;
#(
  parameter int DIV_W = 11,
  parameter int LO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_lo_we,
  input  logic             div_hi_we,
  input  logic [LO_W-1:0]  div_wdata,
  input  logic             frm_we,
  input  frm_cfg_t         frm_wdata,
  output logic [DIV_W-1:0] div_q,
  output frm_cfg_t         frm_q
);
  localparam int HI_W = DIV_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      frm_q <= '0;
    end else begin
      if (div_lo_we) lo_q <= div_wdata;
      if (div_hi_we) hi_q <= div_wdata[HI_W-1:0];
      if (frm_we)    frm_q <= frm_wdata;
    end
  end

  assign div_q = {hi_q, lo_q};
endmodule

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
  parameter int DIV_W = 11,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             bit_end
);
  localparam int OVS_W = $clog2(OVS);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_div;
  logic [OVS_W-1:0] cnt_ovs;
  logic             os_tick;

  assign os_tick = run && (cnt_div == div_q);
  assign bit_end = os_tick && (cnt_ovs == OVS_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt_div <= '0;
      cnt_ovs <= '0;
    end else if (restart) begin
      div_q   <= div_in;
      cnt_div <= '0;
      cnt_ovs <= '0;
    end else if (run) begin
      if (os_tick) begin
        cnt_div <= '0;
        cnt_ovs <= cnt_ovs + 1'b1;
      end else begin
        cnt_div <= cnt_div + 1'b1;
      end
    end
  end

  p_div_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_div <= div_q));

  p_div_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && $past(run)) |-> $stable(div_q));
endmodule

// File: rtl/utx_frame_build.sv
module utx_frame_build
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  frm_cfg_t           cfg,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  int   ndata;
  int   pos;
  logic has_par;
  logic par_bit;
  logic [MAX_DATA-1:0] dbits;

  always_comb begin
    case (cfg.len)
      LEN_7:   ndata = 7;
      LEN_9, LEN_9_LOOP: ndata = 9;
      default: ndata = 8;
    endcase

    dbits = {cfg.bit9, data};
    if (ndata == 7) dbits[MAX_DATA-1:7] = '0;

    has_par = cfg.pen && (ndata != 9);
    case (cfg.pmode)
      PAR_ODD:   par_bit = ~(^dbits[7:0]);
      PAR_EVEN:  par_bit = ^dbits[7:0];
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < ndata) frame[1 + i] = dbits[i];
    end
    pos = 1 + ndata;
    if (has_par) begin
      frame[pos] = par_bit;
      pos = pos + 1;
    end
    nbits = CNT_W'(pos + 1 + int'(cfg.stop2));
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               bit_end,
  output logic               busy,
  output logic               line
);
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (start) begin
      frame_q <= frame_in;
      left_q  <= nbits_in;
      busy_q  <= 1'b1;
    end else if (busy_q && bit_end) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign line = frame_q[0];

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !line);

  p_stop_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(line));
endmodule

// File: rtl/utx_frame_tx.sv
module utx_frame_tx
  import utx_pkg::*;
#(
  parameter int DIV_W  = 11,
  parameter int LO_W   = 8,
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_div_lo_we,
  input  logic              cfg_div_hi_we,
  input  logic [LO_W-1:0]   cfg_div_wdata,
  input  logic              cfg_frm_we,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop2,
  input  logic              cfg_bit9,
  input  logic [1:0]        cfg_pmode,
  input  logic              cfg_pen,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              tx_line,
  output logic              busy,
  output logic              loop_en
);
  frm_cfg_t           frm_w;
  frm_cfg_t           frm_q;
  logic [DIV_W-1:0]   div_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               start;
  logic               bit_end;

  assign frm_w = '{len: len_e'(cfg_len), stop2: cfg_stop2, bit9: cfg_bit9,
                   pmode: pmode_e'(cfg_pmode), pen: cfg_pen};

  utx_cfg_regs #(.DIV_W(DIV_W), .LO_W(LO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_lo_we (cfg_div_lo_we),
    .div_hi_we (cfg_div_hi_we),
    .div_wdata (cfg_div_wdata),
    .frm_we    (cfg_frm_we),
    .frm_wdata (frm_w),
    .div_q     (div_q),
    .frm_q     (frm_q)
  );

  utx_frame_build #(.DATA_W(DATA_W)) u_build (
    .cfg   (frm_q),
    .data  (in_data),
    .frame (frame),
    .nbits (nbits)
  );

  assign in_ready = !busy;
  assign start    = in_valid && in_ready;

  utx_baud_gen #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .run     (busy),
    .div_in  (div_q),
    .bit_end (bit_end)
  );

  utx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .frame_in (frame),
    .nbits_in (nbits),
    .bit_end  (bit_end),
    .busy     (busy),
    .line     (tx_line)
  );

  assign loop_en = (frm_q.len == LEN_9_LOOP);

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(u_shift.frame_q) || !$past(busy) || $past(bit_end));
endmodule

// File: tb/tb_utx_frame_tx.sv
`timescale 1ns/1ps
module tb_utx_frame_tx;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_div_lo_we = 0, cfg_div_hi_we = 0, cfg_frm_we = 0;
  logic [7:0] cfg_div_wdata = 0;
  logic [1:0] cfg_len = 0, cfg_pmode = 0;
  logic cfg_stop2 = 0, cfg_bit9 = 0, cfg_pen = 0;
  logic in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, tx_line, busy, loop_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  utx_frame_tx dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_div_lo_we(cfg_div_lo_we), .cfg_div_hi_we(cfg_div_hi_we),
    .cfg_div_wdata(cfg_div_wdata), .cfg_frm_we(cfg_frm_we),
    .cfg_len(cfg_len), .cfg_stop2(cfg_stop2), .cfg_bit9(cfg_bit9),
    .cfg_pmode(cfg_pmode), .cfg_pen(cfg_pen),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tx_line(tx_line), .busy(busy), .loop_en(loop_en)
  );

  // {len[31:30], stop2[29], bit9[28], pmode[27:26], pen[25], data[24:17], frame[16:4], nbits[3:0]}
  localparam logic [31:0] VEC [10] = '{
    {2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 8'hA5, 13'h034A, 4'd10},
    {2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h03, 13'h0606, 4'd11},
    {2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 8'h03, 13'h0406, 4'd11},
    {2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 8'h00, 13'h0E00, 4'd12},
    {2'd0, 1'b0, 1'b0, 2'd3, 1'b1, 8'hFF, 13'h05FE, 4'd11},
    {2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'hFF, 13'h01FE, 4'd9},
    {2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 8'h81, 13'h0302, 4'd10},
    {2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 8'h00, 13'h0600, 4'd11},
    {2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 8'h55, 13'h0CAA, 4'd12},
    {2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 8'h0F, 13'h021E, 4'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_frm(input logic [1:0] len, input logic s2, input logic b9,
                           input logic [1:0] pm, input logic pen);
    @(negedge clk);
    cfg_len = len; cfg_stop2 = s2; cfg_bit9 = b9; cfg_pmode = pm; cfg_pen = pen;
    cfg_frm_we = 1;
    @(negedge clk);
    cfg_frm_we = 0;
  endtask

  task automatic write_div(input logic [7:0] lo, input logic [2:0] hi);
    @(negedge clk);
    cfg_div_wdata = lo; cfg_div_lo_we = 1;
    @(negedge clk);
    cfg_div_lo_we = 0; cfg_div_wdata = {5'd0, hi}; cfg_div_hi_we = 1;
    @(negedge clk);
    cfg_div_hi_we = 0;
  endtask

  // Sends one byte and checks every bit at mid-bit, then the idle state after the frame.
  task automatic run_frame(input string tag, input logic [7:0] d,
                           input logic [12:0] exp, input int n, input int p);
    @(negedge clk);
    check({tag, " R2 ready idle"}, {31'd0, in_ready}, 32'd1);
    in_valid = 1; in_data = d;
    @(posedge clk);
    #1 in_valid = 0;
    for (int i = 0; i < n; i++) begin
      repeat ((i == 0) ? p / 2 : p) @(posedge clk);
      #2;
      if (i == 0) check({tag, " R2 busy in frame"}, {30'd0, busy, in_ready}, 32'd2);
      check($sformatf("%s R3 bit %0d", tag, i), {31'd0, tx_line}, {31'd0, exp[i]});
    end
    repeat (p - p / 2) @(posedge clk);
    #2;
    check({tag, " R3 idle after frame"}, {30'd0, busy, tx_line}, 32'd1);
  endtask

  task automatic start_len(input logic [7:0] d, input int exp_p, input string tag);
    int k;
    @(negedge clk);
    in_valid = 1; in_data = d;
    @(posedge clk);
    #2 in_valid = 0;
    k = 0;
    while (tx_line == 0 && k < 10000) begin
      k++;
      @(posedge clk);
      #2;
    end
    check(tag, k, exp_p);
    wait (!busy);
  endtask

  initial begin
    #1900000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset outputs", {28'd0, tx_line, busy, in_ready, loop_en}, 32'b1010);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);

    // R1 R4: defaults give 8N1 at 16 clocks per bit
    run_frame("R1 default frame", 8'hA5, 13'h034A, 10, 16);

    // Table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < 10; v++) begin
      logic [31:0] e;
      e = VEC[v];
      write_frm(e[31:30], e[29], e[28], e[27:26], e[25]);
      #2 check($sformatf("R9 loop flag vec %0d", v), {31'd0, loop_en}, {31'd0, e[31:30] == 2'd3});
      run_frame($sformatf("R5 R6 R7 R8 vec %0d", v), e[24:17], e[16:4], int'(e[3:0]), 16);
    end

    // R4: divisor 2 gives 48 clocks per bit
    write_frm(2'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    write_div(8'd2, 3'd0);
    run_frame("R4 div 2", 8'hA5, 13'h034A, 10, 48);
    start_len(8'hFF, 48, "R4 start width div 2");

    // R4: high divisor bits, D = 256
    write_div(8'd0, 3'd1);
    start_len(8'hFF, 4112, "R4 start width div 256");
    write_div(8'd0, 3'd0);

    // R10 and R2: mid-frame writes and stray valid are ignored by the current frame
    fork
      run_frame("R10 old format kept", 8'hA5, 13'h034A, 10, 16);
      begin
        repeat (30) @(posedge clk);
        write_frm(2'd1, 1'b0, 1'b0, 2'd1, 1'b1);
        write_div(8'd1, 3'd0);
        @(negedge clk);
        in_valid = 1; in_data = 8'h00;
        repeat (5) @(negedge clk);
        check("R2 ready low while busy", {31'd0, in_ready}, 32'd0);
        in_valid = 0;
      end
    join
    repeat (5) @(posedge clk);
    #2 check("R2 no extra frame", {30'd0, busy, tx_line}, 32'd1);
    run_frame("R10 new format applied", 8'h81, 13'h0302, 10, 32);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule